// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the raw D+/D- line pair of a low-speed USB link into a stream of data bytes. It runs from a clock eight times the bit rate. Both line inputs pass through a synchronizer. The receiver then hunts for a J-to-K transition inside the sync field and times its bit samples from that edge. A sync is accepted only when two K bit times follow one another. After sync the bit stream is NRZI-decoded, stuffed bits are removed, and the bits are packed least significant first into bytes.

Each finished byte appears on a byte output with a one-cycle valid strobe, and a running count of the packet's bytes is kept. Single pulses mark packet start, a clean end of packet (SE0), a bit-stuffing violation, a packet longer than the configured limit, and a keepalive event. The keepalive event is a lone edge that is not followed by another edge within a bounded time. PID, CRC and transaction handling are done elsewhere.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all pulse outputs are low, the byte output is 0x00 and the byte count is 0. The line is then treated as idle J (J: D+ = 0, D- = 1; K: D+ = 1, D- = 0).
- R2: A J-to-K edge starts an alignment. The line is sampled 1.5 bit times after that edge. If the sample is K, `rx_pkt_start` pulses and data reception begins one bit time later. If it is not K, the receiver drops that alignment and waits for the next J-to-K edge.
- R3: Data bits are NRZI-decoded: an unchanged D- level gives 1 and a changed level gives 0. The first data bit is compared against the final K of sync. Bits enter bytes LSB first, and each complete byte is shown on `rx_byte` with a one-cycle `rx_byte_valid`.
- R4: The bit after six consecutive decoded 1s is dropped and not counted as data.
- R5: If the bit after six consecutive 1s is also a 1, `rx_stuff_err` pulses, no byte or end pulse follows, and the receiver returns to hunting.
- R6: SE0 (both lines low) sampled in bit slot 1..7 of a byte ends the packet with `rx_pkt_end` and discards the partial byte. SE0 sampled in slot 0 is decoded as a K level.
- R7: A byte that would take the packet beyond MAX_BYTES is not emitted. Instead `rx_overflow` pulses and the packet is aborted without an end pulse.
- R8: If no new J-to-K edge arrives within TIMEOUT_BITS bit times after a rejected alignment, `rx_keepalive` pulses and the receiver returns to idle.
- R9: `rx_byte_count` clears at packet start, rises by one with each emitted byte and holds its value after the packet ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OVERSAMPLE ticks per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Last received data byte |
| rx_byte_valid | output | 1 | One-cycle strobe for a new byte |
| rx_pkt_start | output | 1 | Pulse when sync is accepted |
| rx_pkt_end | output | 1 | Pulse on end of packet (SE0) |
| rx_byte_count | output | $clog2(MAX_BYTES+1) | Bytes received in the current or last packet |
| rx_overflow | output | 1 | Pulse when the byte limit is exceeded |
| rx_stuff_err | output | 1 | Pulse on a bit-stuffing violation |
| rx_keepalive | output | 1 | Pulse when a lone edge times out |

## Verification
The hardest cases to reach are the slot-dependent SE0 rule and the stuffing abort. Both need a precise bit position inside a byte after a valid sync. The bench drives a line-level encoder that performs real NRZI and stuffing. To reach these cases it deliberately breaks encoding: it inserts a one-bit SE0 exactly at a byte boundary, adds a dribble bit before the end of packet, and sends seven unchanged levels with no stuffing. A behavioural model then follows every sample tick and compares all outputs on each clock.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_ALIGN = 2'd1,
      RX_HUNT  = 2'd2,
      RX_RECV  = 2'd3
   } rx_state_e;

   localparam int STUFF_RUN = 6;

   function automatic logic lvl_is_j(input logic dp, input logic dm);
      return !dp && dm;
   endfunction

   function automatic logic lvl_is_k(input logic dp, input logic dm);
      return dp && !dm;
   endfunction

   function automatic logic lvl_is_se0(input logic dp, input logic dm);
      return !dp && !dm;
   endfunction
endpackage

// File: rtl/usbrx_linesync.sv
module usbrx_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_i,
   input  logic dm_i,
   output logic dp_o,
   output logic dm_o
);
   logic [STAGES-1:0] dp_q;
   logic [STAGES-1:0] dm_q;

   // reset value is the idle J level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_q <= '0;
         dm_q <= '1;
      end else begin
         dp_q <= {dp_q[STAGES-2:0], dp_i};
         dm_q <= {dm_q[STAGES-2:0], dm_i};
      end
   end

   assign dp_o = dp_q[STAGES-1];
   assign dm_o = dm_q[STAGES-1];
endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer
   import usbrx_pkg::*;
#(
   parameter int OS           = 8,
   parameter int TIMEOUT_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_s,
   input  logic dm_s,
   input  logic stop_i,
   output logic start_stb_o,
   output logic bit_stb_o,
   output logic keepalive_o
);
   localparam int CHK     = OS + OS/2 - 1;
   localparam int PH_W    = $clog2(CHK + 1);
   localparam int TO_LAST = TIMEOUT_BITS*OS - 1;
   localparam int TO_W    = $clog2(TO_LAST + 1);

   rx_state_e        state_q;
   logic [PH_W-1:0]  ph_q;
   logic [TO_W-1:0]  to_q;
   logic             prev_j_q;
   logic             line_j, line_k, edge_jk;

   always_comb begin
      line_j      = lvl_is_j(dp_s, dm_s);
      line_k      = lvl_is_k(dp_s, dm_s);
      edge_jk     = prev_j_q && line_k;
      start_stb_o = (state_q == RX_ALIGN) && (ph_q == PH_W'(CHK)) && line_k;
      bit_stb_o   = (state_q == RX_RECV) && (ph_q == PH_W'(OS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         ph_q        <= '0;
         to_q        <= '0;
         prev_j_q    <= 1'b0;
         keepalive_o <= 1'b0;
      end else begin
         prev_j_q    <= line_j;
         keepalive_o <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (edge_jk) begin
                  state_q <= RX_ALIGN;
                  ph_q    <= '0;
               end
            end
            RX_ALIGN: begin
               if (ph_q == PH_W'(CHK)) begin
                  ph_q <= '0;
                  if (line_k) begin
                     state_q <= RX_RECV;
                  end else begin
                     state_q <= RX_HUNT;
                     to_q    <= '0;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            RX_HUNT: begin
               if (edge_jk) begin
                  state_q <= RX_ALIGN;
                  ph_q    <= '0;
               end else if (to_q == TO_W'(TO_LAST)) begin
                  state_q     <= RX_IDLE;
                  keepalive_o <= 1'b1;
               end else begin
                  to_q <= to_q + 1'b1;
               end
            end
            RX_RECV: begin
               if (bit_stb_o) begin
                  ph_q <= '0;
                  if (stop_i) state_q <= RX_IDLE;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R8: a keepalive can only follow a hunt that ran out
   p_keepalive_from_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      keepalive_o |-> $past(state_q == RX_HUNT));

   // R2: reception is entered only from alignment with the line at K
   p_recv_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_RECV && $past(state_q) != RX_RECV)
         |-> ($past(state_q == RX_ALIGN) && $past(line_k)));
endmodule

// File: rtl/usbrx_decoder.sv
module usbrx_decoder
   import usbrx_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             bit_stb_i,
   input  logic             dp_s,
   input  logic             dm_s,
   output logic             stop_o,
   output logic [7:0]       byte_o,
   output logic             byte_valid_o,
   output logic             pkt_start_o,
   output logic             pkt_end_o,
   output logic [CNT_W-1:0] count_o,
   output logic             stuff_err_o,
   output logic             overflow_o
);
   logic       lvl_q;
   logic [2:0] ones_q;
   logic [2:0] slot_q;
   logic [7:0] shift_q;
   logic       se0, end_hit, stuff_pos, nrzi_one, stuff_hit, full_hit, count_full;
   logic [7:0] next_shift;

   always_comb begin
      se0        = lvl_is_se0(dp_s, dm_s);
      nrzi_one   = (dm_s == lvl_q);
      stuff_pos  = (ones_q == 3'(STUFF_RUN));
      count_full = (count_o == CNT_W'(MAX_BYTES));
      next_shift = {nrzi_one, shift_q[7:1]};
      end_hit    = bit_stb_i && se0 && (slot_q != 3'd0);
      stuff_hit  = bit_stb_i && !end_hit && stuff_pos && nrzi_one;
      full_hit   = bit_stb_i && !end_hit && !stuff_pos && (slot_q == 3'd7) && count_full;
      stop_o     = end_hit || stuff_hit || full_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q        <= 1'b0;
         ones_q       <= '0;
         slot_q       <= '0;
         shift_q      <= '0;
         byte_o       <= '0;
         byte_valid_o <= 1'b0;
         pkt_start_o  <= 1'b0;
         pkt_end_o    <= 1'b0;
         count_o      <= '0;
         stuff_err_o  <= 1'b0;
         overflow_o   <= 1'b0;
      end else begin
         byte_valid_o <= 1'b0;
         pkt_start_o  <= 1'b0;
         pkt_end_o    <= 1'b0;
         stuff_err_o  <= 1'b0;
         overflow_o   <= 1'b0;
         if (start_i) begin
            lvl_q       <= 1'b0;
            ones_q      <= '0;
            slot_q      <= '0;
            count_o     <= '0;
            pkt_start_o <= 1'b1;
         end else if (bit_stb_i) begin
            if (end_hit) begin
               pkt_end_o <= 1'b1;
            end else begin
               lvl_q <= dm_s;
               if (stuff_pos) begin
                  if (nrzi_one) stuff_err_o <= 1'b1;
                  else          ones_q      <= '0;
               end else begin
                  ones_q  <= nrzi_one ? ones_q + 3'd1 : 3'd0;
                  shift_q <= next_shift;
                  if (slot_q == 3'd7) begin
                     slot_q <= '0;
                     if (count_full) begin
                        overflow_o <= 1'b1;
                     end else begin
                        byte_o       <= next_shift;
                        byte_valid_o <= 1'b1;
                        count_o      <= count_o + 1'b1;
                     end
                  end else begin
                     slot_q <= slot_q + 3'd1;
                  end
               end
            end
         end
      end
   end

   // R7: the count never passes the limit
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_W'(MAX_BYTES));

   // R4: a run of ones never exceeds the stuffing length
   p_ones_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= 3'(STUFF_RUN));

   // R9: each emitted byte raises the count by exactly one
   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> (count_o == $past(count_o) + 1'b1));

   // R3: byte strobes are single-cycle
   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |=> !byte_valid_o);

   // R6: packet events are mutually exclusive
   p_events_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_start_o, pkt_end_o, stuff_err_o, overflow_o}));
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
   parameter int OVERSAMPLE   = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int MAX_BYTES    = 8,
   parameter int TIMEOUT_BITS = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             usb_dp,
   input  logic                             usb_dm,
   output logic [7:0]                       rx_byte,
   output logic                             rx_byte_valid,
   output logic                             rx_pkt_start,
   output logic                             rx_pkt_end,
   output logic [$clog2(MAX_BYTES+1)-1:0]   rx_byte_count,
   output logic                             rx_overflow,
   output logic                             rx_stuff_err,
   output logic                             rx_keepalive
);
   localparam int CNT_W = $clog2(MAX_BYTES + 1);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MAX_BYTES < 1) begin : g_bad_max
         $error("MAX_BYTES must be at least 1");
      end
      if (TIMEOUT_BITS < 2) begin : g_bad_to
         $error("TIMEOUT_BITS must be at least 2");
      end
   endgenerate

   logic dp_s, dm_s, start_stb, bit_stb, stop;

   usbrx_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .dp_i (usb_dp),
      .dm_i (usb_dm),
      .dp_o (dp_s),
      .dm_o (dm_s)
   );

   usbrx_framer #(.OS(OVERSAMPLE), .TIMEOUT_BITS(TIMEOUT_BITS)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .dp_s       (dp_s),
      .dm_s       (dm_s),
      .stop_i     (stop),
      .start_stb_o(start_stb),
      .bit_stb_o  (bit_stb),
      .keepalive_o(rx_keepalive)
   );

   usbrx_decoder #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_stb),
      .bit_stb_i   (bit_stb),
      .dp_s        (dp_s),
      .dm_s        (dm_s),
      .stop_o      (stop),
      .byte_o      (rx_byte),
      .byte_valid_o(rx_byte_valid),
      .pkt_start_o (rx_pkt_start),
      .pkt_end_o   (rx_pkt_end),
      .count_o     (rx_byte_count),
      .stuff_err_o (rx_stuff_err),
      .overflow_o  (rx_overflow)
   );
endmodule

// File: tb/test_usb_ls_rx.sv
`timescale 1ns/1ps
module test_usb_ls_rx;
   localparam int OS   = 8;
   localparam int MAXB = 8;
   localparam int TOB  = 16;
   localparam int CW   = $clog2(MAXB + 1);

   logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
   logic [7:0] rx_byte;
   logic rx_byte_valid, rx_pkt_start, rx_pkt_end, rx_overflow, rx_stuff_err, rx_keepalive;
   logic [CW-1:0] rx_byte_count;

   always #2 clk = ~clk;

   usb_ls_rx #(.OVERSAMPLE(OS), .SYNC_STAGES(2), .MAX_BYTES(MAXB), .TIMEOUT_BITS(TOB)) i_usb_ls_rx (
      .clk(clk), .rst_n(rst_n), .usb_dp(dp), .usb_dm(dm),
      .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_pkt_start(rx_pkt_start),
      .rx_pkt_end(rx_pkt_end), .rx_byte_count(rx_byte_count), .rx_overflow(rx_overflow),
      .rx_stuff_err(rx_stuff_err), .rx_keepalive(rx_keepalive));

   int n_checks = 0, n_err = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference, one step per clock ----------------
   bit m1p = 0, m1m = 1, m2p = 0, m2m = 1, mpj = 0;
   int mst = 0, mph = 0, mto = 0, mones = 0, mslot = 0, mcnt = 0;
   bit mlvl = 0;
   logic [7:0] msh = 0, e_data = 0;
   bit e_val = 0, e_sta = 0, e_end = 0, e_ovf = 0, e_stf = 0, e_kee = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m1p = 0; m1m = 1; m2p = 0; m2m = 1; mpj = 0; mst = 0; mph = 0; mto = 0;
         mones = 0; mslot = 0; mcnt = 0; mlvl = 0; msh = 0; e_data = 0;
         e_val = 0; e_sta = 0; e_end = 0; e_ovf = 0; e_stf = 0; e_kee = 0;
      end else begin
         bit isj, isk, b;
         isj = !m2p && m2m;
         isk = m2p && !m2m;
         e_val = 0; e_sta = 0; e_end = 0; e_ovf = 0; e_stf = 0; e_kee = 0;
         if (mst == 0) begin
            if (mpj && isk) begin mst = 1; mph = 0; end
         end else if (mst == 1) begin
            if (mph == OS + OS/2 - 1) begin
               mph = 0;
               if (isk) begin
                  mst = 3; e_sta = 1; mlvl = 0; mones = 0; mslot = 0; mcnt = 0;
               end else begin
                  mst = 2; mto = 0;
               end
            end else mph++;
         end else if (mst == 2) begin
            if (mpj && isk) begin mst = 1; mph = 0; end
            else if (mto == TOB*OS - 1) begin mst = 0; e_kee = 1; end
            else mto++;
         end else begin
            if (mph == OS - 1) begin
               mph = 0;
               if (!m2p && !m2m && mslot != 0) begin
                  e_end = 1; mst = 0;
               end else begin
                  b = (m2m == mlvl);
                  mlvl = m2m;
                  if (mones == 6) begin
                     if (b) begin e_stf = 1; mst = 0; end
                     else mones = 0;
                  end else begin
                     mones = b ? mones + 1 : 0;
                     msh = {b, msh[7:1]};
                     if (mslot == 7) begin
                        mslot = 0;
                        if (mcnt == MAXB) begin e_ovf = 1; mst = 0; end
                        else begin e_data = msh; e_val = 1; mcnt++; end
                     end else mslot++;
                  end
               end
            end else mph++;
         end
         mpj = isj;
         m2p = m1p; m2m = m1m;
         m1p = dp;  m1m = dm;
      end
   end

   // ---------------- per-clock comparison and event capture ----------------
   logic [7:0] got_q[$];
   int n_sta = 0, n_end = 0, n_ovf = 0, n_stf = 0, n_kee = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rx_byte_valid == e_val, "R3 valid", rx_byte_valid, e_val);
         check(rx_byte == e_data, "R3 byte", rx_byte, e_data);
         check(rx_pkt_start == e_sta, "R2 start", rx_pkt_start, e_sta);
         check(rx_pkt_end == e_end, "R6 end", rx_pkt_end, e_end);
         check(rx_byte_count == CW'(mcnt), "R9 count", rx_byte_count, mcnt);
         check(rx_overflow == e_ovf, "R7 overflow", rx_overflow, e_ovf);
         check(rx_stuff_err == e_stf, "R5 stuff", rx_stuff_err, e_stf);
         check(rx_keepalive == e_kee, "R8 keepalive", rx_keepalive, e_kee);
         if (rx_byte_valid) got_q.push_back(rx_byte);
         if (rx_pkt_start) n_sta++;
         if (rx_pkt_end)   n_end++;
         if (rx_overflow)  n_ovf++;
         if (rx_stuff_err) n_stf++;
         if (rx_keepalive) n_kee++;
      end
   end

   // ---------------- line-level stimulus ----------------
   bit cur = 1;       // D- level: 1 = J, 0 = K
   int run = 0;
   logic [7:0] exp_q[$];

   task automatic lvl(input bit l);
      cur = l; dp = !l; dm = l;
      repeat (OS) @(negedge clk);
   endtask

   task automatic se0_bits(input int n);
      dp = 0; dm = 0;
      repeat (n*OS) @(negedge clk);
   endtask

   task automatic sync_field();
      lvl(0); lvl(1); lvl(0); lvl(1); lvl(0); lvl(1); lvl(0); lvl(0);
      run = 0;
   endtask

   task automatic tx_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         if (v[i]) begin lvl(cur); run++; end
         else begin lvl(!cur); run = 0; end
         if (run == 6) begin lvl(!cur); run = 0; end
      end
      exp_q.push_back(v);
   endtask

   task automatic eop();
      se0_bits(2); lvl(1);
   endtask

   task automatic settle();
      for (int i = 0; i < 4; i++) lvl(1);
   endtask

   task automatic clear_events();
      got_q.delete(); exp_q.delete();
      n_sta = 0; n_end = 0; n_ovf = 0; n_stf = 0; n_kee = 0;
   endtask

   task automatic cmp_bytes(input string req);
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_err++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check(rx_byte == 8'h00, "R1 byte at reset", rx_byte, 0);
      check(rx_byte_valid == 0 && rx_pkt_start == 0 && rx_pkt_end == 0, "R1 pulses at reset",
            {rx_byte_valid, rx_pkt_start, rx_pkt_end}, 0);
      check(rx_byte_count == 0, "R1 count at reset", rx_byte_count, 0);
      check(rx_overflow == 0 && rx_stuff_err == 0 && rx_keepalive == 0, "R1 errors at reset",
            {rx_overflow, rx_stuff_err, rx_keepalive}, 0);
      rst_n = 1;
      settle();

      // R2/R3: plain packet, sync rejections happen inside the sync field
      clear_events();
      sync_field(); tx_byte(8'hC3); tx_byte(8'h5A); tx_byte(8'h00); eop(); settle();
      check(n_sta == 1, "R2 one start", n_sta, 1);
      check(n_end == 1, "R6 one end", n_end, 1);
      cmp_bytes("R3 bytes");
      check(rx_byte_count == 3, "R9 count held", rx_byte_count, 3);

      // R4: stuffing in long runs of ones
      clear_events();
      sync_field(); tx_byte(8'hFF); tx_byte(8'hFF); tx_byte(8'h7E); eop(); settle();
      cmp_bytes("R4 unstuffed bytes");
      check(n_end == 1, "R4 end", n_end, 1);

      // R6: dribble bit before SE0
      clear_events();
      sync_field(); tx_byte(8'h2D); lvl(cur); eop(); settle();
      cmp_bytes("R6 dribble bytes");
      check(n_end == 1, "R6 dribble end", n_end, 1);
      check(rx_byte_count == 1, "R9 count after dribble", rx_byte_count, 1);

      // R6: one-bit SE0 in slot 0 is decoded as K
      clear_events();
      sync_field(); tx_byte(8'h11);
      begin
         logic [7:0] b2;
         b2 = 8'h7C | {7'd0, (cur == 1'b0)};
         se0_bits(1); cur = 0;
         lvl(1); lvl(1); lvl(1); lvl(1); lvl(1); lvl(1); lvl(0);
         exp_q.push_back(b2);
      end
      eop(); settle();
      cmp_bytes("R6 slot0 SE0 bytes");
      check(n_end == 1, "R6 slot0 end", n_end, 1);

      // R5: seven unchanged levels
      clear_events();
      sync_field(); tx_byte(8'h00);
      for (int i = 0; i < 7; i++) lvl(cur);
      settle(); settle();
      check(n_stf == 1, "R5 stuff error", n_stf, 1);
      check(n_end == 0, "R5 no end", n_end, 0);
      cmp_bytes("R5 bytes before error");

      // R7: one byte too many
      clear_events();
      sync_field();
      for (int i = 0; i < MAXB + 1; i++) tx_byte(8'hA5);
      void'(exp_q.pop_back());
      eop(); settle();
      check(n_ovf == 1, "R7 overflow", n_ovf, 1);
      check(n_end == 0, "R7 no end", n_end, 0);
      cmp_bytes("R7 bytes kept");
      check(rx_byte_count == MAXB, "R7 count at limit", rx_byte_count, MAXB);

      // R8: lone K then long idle
      clear_events();
      lvl(0);
      for (int i = 0; i < TOB + 6; i++) lvl(1);
      check(n_kee == 1, "R8 keepalive", n_kee, 1);
      check(n_sta == 0, "R8 no start", n_sta, 0);

      // R2: short glitch then a real packet still locks
      clear_events();
      dp = 1; dm = 0; repeat (2) @(negedge clk); settle();
      sync_field(); tx_byte(8'h69); eop(); settle();
      check(n_sta == 1, "R2 start after glitch", n_sta, 1);
      cmp_bytes("R2 bytes after glitch");
      settle(); settle(); settle(); settle(); settle();

      done = 1;
      report();
      $finish;
   end
endmodule